// File: doc/BRIEF.md
# Card Pick Retry Sequencer

This block runs the pick solenoid of a punched-card reader. When the host requests a card and the reader reports itself ready, the sequencer divides the system clock down to a slow pick tick. It counts that tick through a chain of two decimal stages and a binary stage, and produces a timed solenoid pulse early in each counting window. If no card leading edge is reported before the window wraps, the window starts again and the solenoid fires once more. After a fixed number of complete attempts without a card, the sequencer latches a pick-fail alarm and stops picking.

When the read station sees a card arrive, the sequencer clears its counters and holds. It stays held until the end-of-card event, which marks the last pseudo-column passing the read head. At that event it starts a new sequence, with a one-cycle sync reset pulse, but only if the pick request and ready are both still present. Otherwise it goes idle and waits for a fresh request. Reset and power-on reset both clear everything synchronously.

Top module: `card_pick_sequencer`

## Requirements
- R1: While `rst` or `por` is high at a clock edge, the following cycle shows `solenoidDrive`, `pickFail` and `syncReset` all low, with the attempt count and counters cleared.
- R2: In the idle state, a clock edge that sees `pickCmd` and `ready` both high starts a sequence and raises `syncReset` for exactly one cycle. No sequence starts while either input is low.
- R3: The slow tick advances once every `TICK_DIV` clocks, and only while `pickCmd` and `ready` are both high. Dropping either pauses the attempt without raising the alarm.
- R4: The solenoid rises `SET_POS*TICK_DIV` clocks after the `syncReset` pulse and stays high for `(CLR_POS-SET_POS)*TICK_DIV` clocks.
- R5: Without a card, successive solenoid rises are `WINDOW*TICK_DIV` clocks apart, where `WINDOW = DEC_MOD**NUM_DEC * 2**BIN_BITS`.
- R6: At the falling edge of the `MAX_TRIES`-th complete pulse with no card, `pickFail` rises in the same cycle that the solenoid drops, and no further pulse follows.
- R7: `pickFail` stays high until reset, regardless of `goodPick`, `endOfCard` and `pickCmd`.
- R8: `goodPick` while picking, including during the last attempt, drops the solenoid on the next cycle and prevents the alarm. No further pulse is produced until `endOfCard`, even with `pickCmd` high.
- R9: `endOfCard` after a good pick with `pickCmd` and `ready` high restarts picking with a `syncReset` pulse and a fresh budget of `MAX_TRIES` attempts.
- R10: `endOfCard` after a good pick with `pickCmd` low returns to idle without `syncReset` or a pulse. A later request starts normally.
- R11: `goodPick` and `endOfCard` have no effect while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| por | input | 1 | Synchronous power-on reset, active high |
| pickCmd | input | 1 | Host pick request, level |
| ready | input | 1 | Reader ready (no alarm anywhere), level |
| goodPick | input | 1 | One-cycle event: card leading edge reached the read station |
| endOfCard | input | 1 | One-cycle event: last pseudo-column of the card passed |
| solenoidDrive | output | 1 | Pick solenoid pulse |
| pickFail | output | 1 | Latched pick-fail alarm |
| syncReset | output | 1 | One-cycle pulse to the sync logic when a pick sequence starts |

## Verification
The bench counts solenoid rises exactly around the alarm boundary. An off-by-one attempt counter would show up as five or seven pulses before `pickFail`. It also delivers a good pick during the sixth pulse, which catches a design that latches the alarm while a card is already in the track. Card holding is probed two ways: by leaving the request high after a good pick, which a design that does not hold would answer with further pulses, and by dropping the request before end-of-card, which a design that restarts unconditionally would answer with a `syncReset`. Pausing `ready` mid-sequence catches a tick that keeps counting when the gate is closed.

// File: rtl/pick_seq_pkg.sv
package pick_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD,
    ST_FAIL
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // zero prescaler, window chain and attempt count
    logic countEn;   // gate open: prescaler and chain may advance
    logic bumpTry;   // one attempt completed
  } dpCtrl_t;
endpackage

// File: rtl/pick_seq_datapath.sv
module pick_seq_datapath
  import pick_seq_pkg::*;
#(
  parameter int TICK_DIV = 417,
  parameter int DEC_MOD  = 10,
  parameter int NUM_DEC  = 2,
  parameter int BIN_BITS = 6,
  parameter int POS_W    = 13,
  parameter int TRY_W    = 3
) (
  input  logic             clk,
  input  dpCtrl_t          ctrl,
  output logic             preLast,
  output logic [POS_W-1:0] pos,
  output logic [TRY_W-1:0] tries
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int DIG_W = (DEC_MOD > 1) ? $clog2(DEC_MOD) : 1;

  logic [PRE_W-1:0] preQ;
  logic             tick;
  logic [NUM_DEC:0] carry;
  logic [DIG_W-1:0] digits [NUM_DEC];
  logic [BIN_BITS-1:0] binQ;

  assign preLast = (preQ == PRE_W'(TICK_DIV - 1));
  assign tick    = ctrl.countEn && preLast;
  assign carry[0] = tick;

  always_ff @(posedge clk) begin
    if (ctrl.clearAll) preQ <= '0;
    else if (ctrl.countEn) preQ <= preLast ? '0 : preQ + 1'b1;
  end

  // decimal stages of the window chain
  for (genvar g = 0; g < NUM_DEC; g++) begin : g_dec
    logic [DIG_W-1:0] digitQ;
    logic             atTop;
    assign atTop = (digitQ == DIG_W'(DEC_MOD - 1));
    always_ff @(posedge clk) begin
      if (ctrl.clearAll) digitQ <= '0;
      else if (carry[g]) digitQ <= atTop ? '0 : digitQ + 1'b1;
    end
    assign carry[g+1] = carry[g] && atTop;
    assign digits[g]  = digitQ;
  end

  // binary stage, wraps naturally
  always_ff @(posedge clk) begin
    if (ctrl.clearAll) binQ <= '0;
    else if (carry[NUM_DEC]) binQ <= binQ + 1'b1;
  end

  // linear position within the attempt window
  always_comb begin
    logic [POS_W-1:0] acc;
    acc = POS_W'(binQ);
    for (int i = NUM_DEC - 1; i >= 0; i--) begin
      acc = acc * POS_W'(DEC_MOD) + POS_W'(digits[i]);
    end
    pos = acc;
  end

  always_ff @(posedge clk) begin
    if (ctrl.clearAll) tries <= '0;
    else if (ctrl.bumpTry) tries <= tries + 1'b1;
  end
endmodule

// File: rtl/pick_seq_control.sv
module pick_seq_control
  import pick_seq_pkg::*;
#(
  parameter int SET_POS   = 1,
  parameter int CLR_POS   = 400,
  parameter int MAX_TRIES = 6,
  parameter int WINDOW    = 6400,
  parameter int POS_W     = 13,
  parameter int TRY_W     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por,
  input  logic             pickCmd,
  input  logic             ready,
  input  logic             goodPick,
  input  logic             endOfCard,
  input  logic             preLast,
  input  logic [POS_W-1:0] pos,
  input  logic [TRY_W-1:0] tries,
  output dpCtrl_t          ctrl,
  output logic             solenoidQ,
  output logic             alarmQ,
  output logic             syncQ
);
  seqState_t state, stateNext;
  logic gate, tick, setHit, clrHit, lastTry, startPulse, failEnter;
  logic [POS_W-1:0] nextPos;

  assign gate    = pickCmd && ready;
  assign tick    = (state == ST_RUN) && gate && preLast;
  assign nextPos = (pos == POS_W'(WINDOW - 1)) ? '0 : pos + 1'b1;
  assign setHit  = tick && (nextPos == POS_W'(SET_POS));
  assign clrHit  = tick && (nextPos == POS_W'(CLR_POS));
  assign lastTry = clrHit && (tries == TRY_W'(MAX_TRIES - 1));

  always_comb begin
    stateNext  = state;
    ctrl       = '0;
    startPulse = 1'b0;
    failEnter  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (gate) begin
          stateNext     = ST_RUN;
          ctrl.clearAll = 1'b1;
          startPulse    = 1'b1;
        end
      end
      ST_RUN: begin
        if (goodPick) begin
          stateNext     = ST_HOLD;
          ctrl.clearAll = 1'b1;
        end else if (lastTry) begin
          stateNext     = ST_FAIL;
          ctrl.clearAll = 1'b1;
          failEnter     = 1'b1;
        end else begin
          ctrl.countEn = gate;
          ctrl.bumpTry = clrHit;
        end
      end
      ST_HOLD: begin
        if (endOfCard) begin
          ctrl.clearAll = 1'b1;
          if (gate) begin
            stateNext  = ST_RUN;
            startPulse = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || por) begin
      state     <= ST_IDLE;
      solenoidQ <= 1'b0;
      alarmQ    <= 1'b0;
      syncQ     <= 1'b0;
    end else begin
      state  <= stateNext;
      syncQ  <= startPulse;
      alarmQ <= alarmQ || failEnter;
      if (ctrl.clearAll) solenoidQ <= 1'b0;
      else if (setHit) solenoidQ <= 1'b1;
      else if (clrHit) solenoidQ <= 1'b0;
    end
  end
endmodule

// File: rtl/card_pick_sequencer.sv
module card_pick_sequencer
  import pick_seq_pkg::*;
#(
  parameter int TICK_DIV  = 417,
  parameter int DEC_MOD   = 10,
  parameter int NUM_DEC   = 2,
  parameter int BIN_BITS  = 6,
  parameter int SET_POS   = 1,
  parameter int CLR_POS   = 400,
  parameter int MAX_TRIES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic por,
  input  logic pickCmd,
  input  logic ready,
  input  logic goodPick,
  input  logic endOfCard,
  output logic solenoidDrive,
  output logic pickFail,
  output logic syncReset
);
  localparam int WINDOW = (DEC_MOD ** NUM_DEC) * (2 ** BIN_BITS);
  localparam int POS_W  = $clog2(WINDOW);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);

  dpCtrl_t          ctrl;
  logic             preLast;
  logic [POS_W-1:0] pos;
  logic [TRY_W-1:0] tries;

  pick_seq_datapath #(
    .TICK_DIV(TICK_DIV), .DEC_MOD(DEC_MOD), .NUM_DEC(NUM_DEC),
    .BIN_BITS(BIN_BITS), .POS_W(POS_W), .TRY_W(TRY_W)
  ) dp_i (
    .clk(clk), .ctrl(ctrl), .preLast(preLast), .pos(pos), .tries(tries)
  );

  pick_seq_control #(
    .SET_POS(SET_POS), .CLR_POS(CLR_POS), .MAX_TRIES(MAX_TRIES),
    .WINDOW(WINDOW), .POS_W(POS_W), .TRY_W(TRY_W)
  ) ctl_i (
    .clk(clk), .rst(rst), .por(por), .pickCmd(pickCmd), .ready(ready),
    .goodPick(goodPick), .endOfCard(endOfCard), .preLast(preLast),
    .pos(pos), .tries(tries), .ctrl(ctrl), .solenoidQ(solenoidDrive),
    .alarmQ(pickFail), .syncQ(syncReset)
  );
endmodule

// File: rtl/card_pick_sequencer_chk.sv
module card_pick_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic por,
  input logic pickCmd,
  input logic ready,
  input logic goodPick,
  input logic endOfCard,
  input logic solenoidDrive,
  input logic pickFail,
  input logic syncReset
);
  logic prevRst = 1'b0;
  always @(posedge clk) begin
    if (prevRst) begin
      assert_reset_clears_R1: assert (!solenoidDrive && !pickFail && !syncReset)
        else $error("outputs not cleared after reset");
    end
    prevRst <= rst || por;
  end

  assert_sync_single_R2: assert property (@(posedge clk) disable iff (rst || por)
    syncReset |=> !syncReset);

  assert_rise_needs_gate_R3: assert property (@(posedge clk) disable iff (rst || por)
    $rose(solenoidDrive) |-> $past(pickCmd && ready));

  assert_alarm_ends_pulse_R6: assert property (@(posedge clk) disable iff (rst || por)
    $rose(pickFail) |-> $fell(solenoidDrive));

  assert_no_drive_in_alarm_R6: assert property (@(posedge clk) disable iff (rst || por)
    pickFail |-> !solenoidDrive);

  assert_alarm_sticky_R7: assert property (@(posedge clk) disable iff (rst || por)
    pickFail |=> pickFail);

  assert_goodpick_drops_R8: assert property (@(posedge clk) disable iff (rst || por)
    goodPick |=> !solenoidDrive);
endmodule

bind card_pick_sequencer card_pick_sequencer_chk chk_i (.*);

// File: tb/card_pick_sequencer_test.sv
module card_pick_sequencer_test;
  localparam int TDIV = 2, DMOD = 2, NDEC = 2, BBITS = 3, SETP = 1, CLRP = 5, TRIES = 6;
  localparam int WIN = (DMOD ** NDEC) * (2 ** BBITS);

  logic clk = 1'b0;
  logic rst = 1'b1, por = 1'b1, pickCmd = 1'b0, ready = 1'b0;
  logic goodPick = 1'b0, endOfCard = 1'b0;
  logic solenoidDrive, pickFail, syncReset;

  card_pick_sequencer #(
    .TICK_DIV(TDIV), .DEC_MOD(DMOD), .NUM_DEC(NDEC), .BIN_BITS(BBITS),
    .SET_POS(SETP), .CLR_POS(CLRP), .MAX_TRIES(TRIES)
  ) uut (
    .clk(clk), .rst(rst), .por(por), .pickCmd(pickCmd), .ready(ready),
    .goodPick(goodPick), .endOfCard(endOfCard), .solenoidDrive(solenoidDrive),
    .pickFail(pickFail), .syncReset(syncReset)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0, errors = 0;
  int cyc = 0, riseCnt = 0, pcrCnt = 0;
  int lastRise = -1, lastPcr = -1, width = 0, gap = 0, pcrToRise = 0;
  logic prevSol = 1'b0;
  bit done = 1'b0;

  // stimulus: {good pick during attempt (0 = never), expected pulses, expected alarm}
  localparam int VEC[4][3] = '{'{0, 6, 1}, '{1, 1, 0}, '{3, 3, 0}, '{6, 6, 0}};

  always @(negedge clk) begin
    cyc++;
    if (syncReset) begin pcrCnt++; lastPcr = cyc; end
    if (solenoidDrive && !prevSol) begin
      riseCnt++;
      if (lastRise >= 0) gap = cyc - lastRise;
      if (lastPcr > lastRise) pcrToRise = cyc - lastPcr;
      lastRise = cyc;
    end
    if (!solenoidDrive && prevSol) width = cyc - lastRise;
    prevSol = solenoidDrive;
    if (cyc > 150000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1; pickCmd = 1'b0; ready = 1'b0; goodPick = 1'b0; endOfCard = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; por = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitRises(input int base, input int n);
    for (int g = 0; g < 2000 && (riseCnt - base) < n; g++) @(negedge clk);
  endtask

  task automatic waitAlarm();
    for (int g = 0; g < 2000 && !pickFail; g++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; @(negedge clk); sig = 1'b0;
  endtask

  initial begin
    int base, pbase;
    resetDut();
    check(!solenoidDrive && !pickFail && !syncReset, "R1 reset state", solenoidDrive, 0);
    // R2: no start without both pickCmd and ready; R11: events ignored when idle
    pickCmd = 1'b1; ready = 1'b0;
    repeat (30) @(negedge clk);
    pulse(goodPick); pulse(endOfCard);
    pickCmd = 1'b0; ready = 1'b1;
    repeat (30) @(negedge clk);
    check(pcrCnt == 0 && riseCnt == 0, "R2 no start without gate", pcrCnt, 0);
    check(riseCnt == 0, "R11 idle events ignored", riseCnt, 0);

    // table of scenarios
    for (int v = 0; v < 4; v++) begin
      resetDut();
      base = riseCnt; pbase = pcrCnt;
      pickCmd = 1'b1; ready = 1'b1;
      if (VEC[v][0] == 0) waitAlarm();
      else begin
        waitRises(base, VEC[v][0]);
        repeat (2) @(negedge clk);
        pulse(goodPick);
      end
      repeat (300) @(negedge clk);  // pickCmd stays high: hold must suppress pulses (R8)
      check(riseCnt - base == VEC[v][1], VEC[v][0] == 0 ? "R6 pulse count" : "R8 pulse count",
            riseCnt - base, VEC[v][1]);
      check(pickFail == VEC[v][2], "R6/R8 alarm state", pickFail, VEC[v][2]);
      check(!solenoidDrive, "R6 solenoid low at end", solenoidDrive, 0);
      if (v == 0) begin
        check(pcrCnt - pbase == 1, "R2 single sync pulse", pcrCnt - pbase, 1);
        check(pcrToRise == SETP * TDIV, "R4 sync to rise", pcrToRise, SETP * TDIV);
        check(width == (CLRP - SETP) * TDIV, "R4 pulse width", width, (CLRP - SETP) * TDIV);
        check(gap == WIN * TDIV, "R5 attempt period", gap, WIN * TDIV);
        // R7: alarm survives events and request
        pulse(goodPick); pulse(endOfCard);
        pickCmd = 1'b0; repeat (5) @(negedge clk); pickCmd = 1'b1;
        repeat (200) @(negedge clk);
        check(pickFail && (riseCnt - base == 6) && (pcrCnt - pbase == 1), "R7 alarm sticky",
              pickFail, 1);
        rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0; pickCmd = 1'b0;
        check(!pickFail && !solenoidDrive, "R1 reset clears alarm", pickFail, 0);
      end
    end

    // R9: restart after end of card with fresh attempt budget
    resetDut();
    base = riseCnt; pbase = pcrCnt;
    pickCmd = 1'b1; ready = 1'b1;
    waitRises(base, 2);
    pulse(goodPick);
    repeat (50) @(negedge clk);
    pulse(endOfCard);
    @(negedge clk);
    check(pcrCnt - pbase == 2, "R9 restart sync pulse", pcrCnt - pbase, 2);
    waitAlarm();
    repeat (5) @(negedge clk);
    check(pickFail && (riseCnt - base == 8), "R9 fresh attempt budget", riseCnt - base, 8);

    // R10: request dropped before end of card
    resetDut();
    base = riseCnt; pbase = pcrCnt;
    pickCmd = 1'b1; ready = 1'b1;
    waitRises(base, 1);
    pulse(goodPick);
    pickCmd = 1'b0;
    repeat (10) @(negedge clk);
    pulse(endOfCard);
    repeat (200) @(negedge clk);
    check(pcrCnt - pbase == 1 && riseCnt - base == 1, "R10 no restart", pcrCnt - pbase, 1);
    pulse(goodPick); pulse(endOfCard);
    repeat (20) @(negedge clk);
    check(pcrCnt - pbase == 1 && riseCnt - base == 1, "R11 events in idle", riseCnt - base, 1);
    pickCmd = 1'b1;
    repeat (5) @(negedge clk);
    check(pcrCnt - pbase == 2, "R10 later request starts", pcrCnt - pbase, 2);

    // R3: ready drop pauses the attempt
    resetDut();
    base = riseCnt;
    pickCmd = 1'b1; ready = 1'b1;
    waitRises(base, 1);
    repeat (10) @(negedge clk);
    ready = 1'b0;
    repeat (300) @(negedge clk);
    check(riseCnt - base == 1 && !pickFail, "R3 paused without gate", riseCnt - base, 1);
    ready = 1'b1;
    waitAlarm();
    repeat (5) @(negedge clk);
    check(pickFail && riseCnt - base == 6, "R3 resumes to alarm", riseCnt - base, 6);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule